// File: doc/BRIEF.md
# Masked Port Mismatch Detector

This block watches several parallel input ports, eight pins each by default and four ports by default. For every port, software stores an expected pin pattern and a compare-enable pattern. The block raises an event when any enabled pin differs from its expected level. It compares the raw pin levels, so it works the same way however the pins are routed to other peripherals.

Each pin input passes through a synchronizer chain of two flops before the compare. The detector then offers three outputs:
- a level flag that is high while any port mismatches,
- a single-cycle interrupt pulse when that flag rises,
- a wake request, which is the flag level with no register in its path, so a power controller can act on it without a running clock edge.

Software reaches the registers through a plain write-enable, address and data interface, and the read data is combinational. The interrupt controller, the power-mode controller and pin multiplexing live outside this block.

Top module: `port_watch`

## Requirements
- R1: After reset every compare-enable register reads 0x00 and every expected-value register reads 0xFF. The flag, interrupt and wake outputs are low, and stay low whatever the pins do until software enables a pin.
- R2: Address bit 2 selects the register kind (1 = compare-enable, 0 = expected value), and address bits 1:0 select the port. A write with `reg_wr` high stores `reg_wdata`. `reg_rdata` always returns the register selected by `reg_addr`.
- R3: A port mismatches when (pins AND enable) differs from (expected AND enable). Each port is evaluated separately. Port p occupies bits 8p+7:8p of `pins_i`.
- R4: A pin whose enable bit is 0 never causes a mismatch, whatever level it has.
- R5: For an enabled pin, an expected bit of 0 means the pin should be low and an expected bit of 1 means it should be high. The opposite level is a mismatch.
- R6: `miss_flag` is the OR of all per-port mismatches. It stays high as long as any port still mismatches.
- R7: `irq_pulse` is high for exactly one cycle, in the cycle after `miss_flag` rises. It does not repeat while the flag stays high.
- R8: `wake_req` equals `miss_flag` at all times, with no register between them.
- R9: A pin change reaches `miss_flag` after exactly two rising clock edges.
- R10: A register write affects `miss_flag` in the cycle after the write edge, not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Raw pin levels, port p in bits 8p+7:8p |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: bit 2 kind, bits 1:0 port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| miss_flag | output | 1 | Level mismatch flag |
| irq_pulse | output | 1 | One-cycle pulse on a rising mismatch flag |
| wake_req | output | 1 | Unregistered wake request, equal to the flag |

## Verification
The assertions assume that the register interface is driven only while reset is released. They also assume that the pins may change at any time, because the synchronizer absorbs that. The edge checks on the interrupt depend only on the flag history since reset, and the flag is low right after reset because every compare-enable bit resets to 0. The stimulus changes pins and register inputs only on falling clock edges. It always leaves at least two rising edges after a pin change before it judges the flag, and three before it judges the interrupt.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int PW_PORTS  = 4;
  localparam int PW_WIDTH  = 8;
  localparam int PW_STAGES = 2;

  typedef enum logic {
    KIND_EXPECT = 1'b0,
    KIND_ENABLE = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pw_regs.sv
module pw_regs
  import pw_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int SEL_W    = $clog2(NUM_PORTS),
  localparam int ADDR_W   = SEL_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [PORT_W-1:0]                wdata_i,
  output logic [PORT_W-1:0]                rdata_o,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] enable_o,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] expect_o
);
  reg_kind_e        kind;
  logic [SEL_W-1:0] sel;

  assign kind = reg_kind_e'(addr_i[ADDR_W-1]);
  assign sel  = addr_i[SEL_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_i && (sel == SEL_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        enable_o[p] <= '0;
        expect_o[p] <= '1;
      end else if (hit) begin
        if (kind == KIND_ENABLE) enable_o[p] <= wdata_i;
        else                     expect_o[p] <= wdata_i;
      end
    end
  end

  always_comb begin
    if (kind == KIND_ENABLE) rdata_o = enable_o[sel];
    else                     rdata_o = expect_o[sel];
  end

  // R10
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && kind == KIND_ENABLE) |=> (enable_o[$past(sel)] == $past(wdata_i)));

  // R10
  expect_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && kind == KIND_EXPECT) |=> (expect_o[$past(sel)] == $past(wdata_i)));
endmodule

// File: rtl/pw_cmp.sv
module pw_cmp #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic [NUM_PORTS*PORT_W-1:0]      pins_i,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] enable_i,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] expect_i,
  output logic [NUM_PORTS-1:0]             port_miss_o,
  output logic                             any_miss_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] lvl;
    assign lvl = pins_i[p*PORT_W +: PORT_W];
    assign port_miss_o[p] = (lvl & enable_i[p]) != (expect_i[p] & enable_i[p]);
  end

  assign any_miss_o = |port_miss_o;
endmodule

// File: rtl/port_watch.sv
module port_watch
  import pw_pkg::*;
#(
  parameter int NUM_PORTS   = PW_PORTS,
  parameter int PORT_W      = PW_WIDTH,
  parameter int SYNC_STAGES = PW_STAGES,
  localparam int ADDR_W     = $clog2(NUM_PORTS) + 1,
  localparam int PINS_W     = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS_W-1:0] pins_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  output logic              miss_flag,
  output logic              irq_pulse,
  output logic              wake_req
);
  logic [PINS_W-1:0]                pins_s;
  logic [NUM_PORTS-1:0][PORT_W-1:0] enable_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0] expect_q;
  logic [NUM_PORTS-1:0]             port_miss;
  logic                             flag_d;
  logic                             irq_q;

  pw_sync #(.WIDTH(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  pw_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .enable_o (enable_q),
    .expect_o (expect_q)
  );

  pw_cmp #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_cmp (
    .pins_i      (pins_s),
    .enable_i    (enable_q),
    .expect_i    (expect_q),
    .port_miss_o (port_miss),
    .any_miss_o  (miss_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_d <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_d <= miss_flag;
      irq_q  <= miss_flag & ~flag_d;
    end
  end

  assign irq_pulse = irq_q;
  assign wake_req  = miss_flag;

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_flag) |=> irq_pulse);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(miss_flag));

  // R4
  all_ignored_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !miss_flag);

  // R6
  port_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_miss != '0) |-> wake_req);
endmodule

// File: tb/port_watch_bench.sv
module port_watch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins_i = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        miss_flag, irq_pulse, wake_req;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  logic [7:0]  en_m [4];
  logic [7:0]  ex_m [4];
  logic [31:0] seed = 32'h1badf00d;

  always #4 clk = ~clk;

  port_watch u_port_watch (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .miss_flag(miss_flag), .irq_pulse(irq_pulse), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic model_flag(input logic [31:0] p);
    logic f = 1'b0;
    for (int i = 0; i < 4; i++)
      if ((p[i*8 +: 8] & en_m[i]) != (ex_m[i] & en_m[i])) f = 1'b1;
    return f;
  endfunction

  function automatic logic [31:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic wr(input logic kind, input int port, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {kind, 2'(port)}; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
    if (kind) en_m[port] = val; else ex_m[port] = val;
  endtask

  task automatic settle(input logic [31:0] p);
    @(negedge clk);
    pins_i = p;
    repeat (3) step();
  endtask

  task automatic check_flag(input string req);
    chk(req, miss_flag, model_flag(pins_i));
    chk("R8", wake_req, miss_flag);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) begin
      wr(1'b1, i, 8'h00);
      wr(1'b0, i, 8'hFF);
    end
    settle(32'h0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_addr = 3'(i);
      #1;
      chk("R1", reg_rdata, (i >= 4) ? 32'h00 : 32'hFF);
    end
    chk("R1", {miss_flag, irq_pulse, wake_req}, 0);
  endtask

  task automatic t_ignore_all();
    for (int k = 0; k < 20; k++) begin
      settle(next_rand());
      chk("R1", miss_flag, 1'b0);
      chk("R4", irq_pulse, 1'b0);
    end
  endtask

  task automatic t_readback();
    for (int i = 0; i < 4; i++) begin
      wr(1'b1, i, 8'h11 * (i + 1));
      wr(1'b0, i, 8'hA0 + 8'(i));
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_addr = 3'(i);
      #1;
      chk("R2", reg_rdata, (i >= 4) ? 8'h11 * (i - 3) : 8'hA0 + 8'(i));
    end
    clear_all();
  endtask

  task automatic t_partial_mask();
    wr(1'b1, 0, 8'h0F);
    wr(1'b0, 0, 8'h00);
    for (int k = 0; k < 16; k++) begin
      settle({24'h0, 4'(k), 4'h0});
      chk("R4", miss_flag, 1'b0);
    end
    settle(32'h0000_0004);
    chk("R4", miss_flag, 1'b1);
    clear_all();
  endtask

  task automatic t_polarity();
    wr(1'b1, 1, 8'h01);
    wr(1'b0, 1, 8'h01);
    settle(32'h0000_0100); chk("R5", miss_flag, 1'b0);
    settle(32'h0000_0000); chk("R5", miss_flag, 1'b1);
    wr(1'b0, 1, 8'h00);
    step();
    chk("R5", miss_flag, 1'b0);
    settle(32'h0000_0100); chk("R5", miss_flag, 1'b1);
    clear_all();
  endtask

  task automatic t_or_level();
    wr(1'b1, 2, 8'h80);
    wr(1'b1, 3, 8'h01);
    wr(1'b0, 2, 8'h00);
    wr(1'b0, 3, 8'h00);
    settle(32'h0180_0000); chk("R6", miss_flag, 1'b1); chk("R8", wake_req, 1'b1);
    settle(32'h0100_0000); chk("R6", miss_flag, 1'b1);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R6", miss_flag, 1'b1);
      chk("R7", irq_pulse, 1'b0);
    end
    settle(32'h0000_0000); chk("R6", miss_flag, 1'b0); chk("R8", wake_req, 1'b0);
    clear_all();
  endtask

  task automatic t_sync_irq();
    wr(1'b1, 0, 8'hFF);
    wr(1'b0, 0, 8'h00);
    settle(32'h0);
    @(negedge clk);
    pins_i = 32'h0000_0008;
    #1; chk("R9", miss_flag, 1'b0);
    step(); chk("R9", miss_flag, 1'b0);
    step(); chk("R9", miss_flag, 1'b1); chk("R7", irq_pulse, 1'b0);
    step(); chk("R7", irq_pulse, 1'b1);
    step(); chk("R7", irq_pulse, 1'b0); chk("R6", miss_flag, 1'b1);
    settle(32'h0);
    clear_all();
  endtask

  task automatic t_write_timing();
    wr(1'b1, 1, 8'hFF);
    wr(1'b0, 1, 8'h00);
    settle(32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'b001; reg_wdata = 8'h01;
    #1; chk("R10", miss_flag, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0; ex_m[1] = 8'h01;
    #1; chk("R10", miss_flag, 1'b1);
    step(); chk("R7", irq_pulse, 1'b1);
    clear_all();
  endtask

  task automatic t_formula();
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 4; i++) begin
        wr(1'b1, i, 8'(next_rand()));
        wr(1'b0, i, 8'(next_rand()));
      end
      settle(next_rand());
      check_flag("R3");
      if (k % 4 == 0) begin
        for (int i = 0; i < 4; i++) wr(1'b0, i, pins_i[i*8 +: 8]);
        step();
        check_flag("R3");
      end
    end
    clear_all();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin en_m[i] = 8'h00; ex_m[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    #1; chk("R1", {miss_flag, irq_pulse, wake_req}, 0);
    rst_n = 1'b1;
    t_reset();
    t_ignore_all();
    t_readback();
    t_partial_mask();
    t_polarity();
    t_or_level();
    t_sync_irq();
    t_write_timing();
    t_formula();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule